// File: doc/BRIEF.md
# Serial Configuration Sequencer

This block brings up a target device over a one-bit configuration port. On a start pulse it pulses the target's program line and waits for the target's init status to fall. It then releases the program line and waits for init to rise again. Next it clocks the configuration stream out one bit at a time. Last, it waits for the target's done status. Each of the three waits on the target is supervised by a millisecond-based timeout, and each timeout has its own error code. The result is held on `done_ok` and `error_code` until the next start.

Configuration data arrives on a valid/ready stream. A beat is taken on a clock edge where `s_valid` and `s_ready` are both high. Once the source raises `s_valid`, it holds the beat steady until that beat is taken. The block raises `s_ready` only while it is shifting and its internal bit buffer is empty, so the target's bit rate sets the back-pressure. `s_last` marks the final beat. In byte mode each beat carries eight bits, sent most-significant first. In bit mode, which is meant for an upstream decompressor, each beat carries one bit in `s_data[0]`, and a fixed 16-bit sync prefix is sent before the first beat. `bit_mode` is sampled together with `start`.

Top module: `cfg_serial_loader`

## Requirements
- R1: While not busy, the program line is at its inactive level, `cfg_clk` is 1 and `cfg_data` is 1.
- R2: With `PROG_ACTIVE_HIGH` = 0 the program line is asserted as 0 and is 1 when inactive. With `PROG_ACTIVE_HIGH` = 1 the levels are reversed.
- R3: After start the program line is asserted until synchronised `cfg_init` is seen low. If that wait times out, `error_code` becomes 1 and the block returns to idle.
- R4: The program line is then released until synchronised `cfg_init` is seen high. If that wait times out, `error_code` becomes 2.
- R5: Every bit occupies four phases of `PHASE_CLKS` cycles each: (clk 0, data 1), (clk 0, data = bit), (clk 1, data = bit), (clk 1, data 1). Data is therefore stable across every rising `cfg_clk` and is 1 at every falling `cfg_clk`.
- R6: In byte mode (`bit_mode` = 0), each beat's `s_data[7:0]` is sent bit 7 first. No prefix is sent.
- R7: In bit mode (`bit_mode` = 1), the sixteen bits of 0xFF followed by 0x20 are sent most-significant bit first, and then one bit per beat taken from `s_data[0]`.
- R8: After the bit from the beat marked `s_last`, the block waits for synchronised `cfg_done` high. When it sees done high it sets `done_ok` = 1 with `error_code` = 0. If the wait times out, `error_code` becomes 3 with `done_ok` = 0.
- R9: A wait times out after `TIMEOUT_MS` ticks of `CLKS_PER_MS` cycles. The error and the fall of `busy` appear exactly `TIMEOUT_MS*CLKS_PER_MS` cycles after the clock edge that entered the wait.
- R10: `start` is ignored while busy. `done_ok` and `error_code` are cleared on an accepted start and are otherwise held while idle. They are never both set.
- R11: A beat transfers only when `s_valid` and `s_ready` are both high. `s_ready` is 0 whenever the block is not shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a configuration sequence (accepted only when idle) |
| bit_mode | input | 1 | 0 = byte beats, 1 = one-bit beats with sync prefix; sampled with start |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted this edge when also valid |
| s_data | input | BYTE_W | Stream beat payload |
| s_last | input | 1 | Final beat of the stream |
| cfg_init | input | 1 | Target init status (asynchronous) |
| cfg_done | input | 1 | Target done status (asynchronous) |
| cfg_prog | output | 1 | Target program line |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_data | output | 1 | Configuration data to the target |
| busy | output | 1 | Sequence in progress |
| done_ok | output | 1 | Last sequence succeeded |
| error_code | output | 2 | 0 none, 1 init-low timeout, 2 init-high timeout, 3 done timeout |

## Verification
The program line and `busy` change one cycle after an accepted start edge. A timeout and the fall of `busy` land exactly `TIMEOUT_MS*CLKS_PER_MS` cycles after the edge that entered the wait. The bench counts falling-edge samples from the start, or from the first sample that shows the program line released, and compares the count with that figure. Bits are captured at falling system-clock edges at the first sample that shows `cfg_clk` high after a low, which is the second phase-boundary edge of each bit. The result outputs are read at the first sample that shows `busy` low, because they are written on the same edge that returns the block to idle.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_HI,
    ST_SHIFT,
    ST_WAIT_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_INIT_LOW  = 2'd1,
    ERR_INIT_HIGH = 2'd2,
    ERR_DONE      = 2'd3
  } seq_err_e;

  localparam int          PREFIX_W    = 16;
  localparam logic [15:0] SYNC_PREFIX = 16'hFF20;
endpackage

// File: rtl/cfg_sync_in.sv
module cfg_sync_in #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= {STAGES{RST_VAL}};
        else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfg_ms_watch.sv
module cfg_ms_watch #(
  parameter int CLKS_PER_MS = 100000,
  parameter int TIMEOUT_MS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam int TW = (TIMEOUT_MS > 1) ? $clog2(TIMEOUT_MS) : 1;

  logic [CW-1:0] ms_cnt;
  logic [TW-1:0] ticks;
  logic          ms_last;

  assign ms_last = (ms_cnt == CW'(CLKS_PER_MS - 1));
  assign expired = run && ms_last && (ticks == TW'(TIMEOUT_MS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ms_cnt <= '0;
      ticks  <= '0;
    end else if (run) begin
      if (ms_last) begin
        ms_cnt <= '0;
        ticks  <= ticks + 1'b1;
      end else begin
        ms_cnt <= ms_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_bit_feed.sv
module cfg_bit_feed
  import cfg_loader_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              bit_mode,
  input  logic              en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  input  logic              take,
  output logic              bit_valid,
  output logic              bit_val,
  output logic              bit_last
);
  localparam int SH_W  = (BYTE_W > PREFIX_W) ? BYTE_W : PREFIX_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] cnt;
  logic             mode_q;
  logic             tail_q;

  assign s_ready   = en && (cnt == '0) && !tail_q;
  assign bit_valid = (cnt != '0);
  assign bit_val   = sh[SH_W-1];
  assign bit_last  = tail_q && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      mode_q <= 1'b0;
      tail_q <= 1'b0;
    end else if (arm) begin
      mode_q <= bit_mode;
      tail_q <= 1'b0;
      if (bit_mode) begin
        sh  <= SH_W'(SYNC_PREFIX) << (SH_W - PREFIX_W);
        cnt <= CNT_W'(PREFIX_W);
      end else begin
        sh  <= '0;
        cnt <= '0;
      end
    end else if (s_valid && s_ready) begin
      tail_q <= s_last;
      if (mode_q) begin
        sh  <= SH_W'(s_data[0]) << (SH_W - 1);
        cnt <= CNT_W'(1);
      end else begin
        sh  <= SH_W'(s_data) << (SH_W - BYTE_W);
        cnt <= CNT_W'(BYTE_W);
      end
    end else if (take && bit_valid) begin
      sh  <= sh << 1;
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cfg_bit_phaser.sv
module cfg_bit_phaser #(
  parameter int PHASE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_valid,
  input  logic bit_val,
  input  logic bit_last,
  output logic take,
  output logic cfg_clk,
  output logic cfg_data,
  output logic finished
);
  localparam int PW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;

  logic          active;
  logic [1:0]    ph;
  logic [PW-1:0] pcnt;
  logic          cur_bit;
  logic          cur_last;
  logic          phase_end;
  logic          bit_end;

  assign phase_end = (pcnt == PW'(PHASE_CLKS - 1));
  assign bit_end   = active && phase_end && (ph == 2'd3);
  assign take      = en && bit_valid && (!active || (bit_end && !cur_last));
  assign finished  = bit_end && cur_last;

  assign cfg_clk  = !(active && !ph[1]);
  assign cfg_data = (active && (ph == 2'd1 || ph == 2'd2)) ? cur_bit : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      ph       <= '0;
      pcnt     <= '0;
      cur_bit  <= 1'b1;
      cur_last <= 1'b0;
    end else if (take) begin
      active   <= 1'b1;
      ph       <= '0;
      pcnt     <= '0;
      cur_bit  <= bit_val;
      cur_last <= bit_last;
    end else if (bit_end) begin
      active <= 1'b0;
      ph     <= '0;
      pcnt   <= '0;
    end else if (active) begin
      if (phase_end) begin
        ph   <= ph + 1'b1;
        pcnt <= '0;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int CLKS_PER_MS      = 100000,
  parameter int TIMEOUT_MS       = 4,
  parameter int PHASE_CLKS       = 2,
  parameter int BYTE_W           = 8,
  parameter int SYNC_STAGES      = 2,
  parameter bit PROG_ACTIVE_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bit_mode,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  input  logic              cfg_init,
  input  logic              cfg_done,
  output logic              cfg_prog,
  output logic              cfg_clk,
  output logic              cfg_data,
  output logic              busy,
  output logic              done_ok,
  output logic [1:0]        error_code
);
  seq_state_e state_q, state_d;
  seq_err_e   err_q, fin_err;
  logic       ok_q, fin, fin_ok;
  logic       init_s, done_s;
  logic       expired, wait_run, wait_clear, arm, shifting;
  logic       take, bit_valid, bit_val, bit_last, finished;

  cfg_sync_in #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_init_sync (
    .clk(clk), .rst_n(rst_n), .d(cfg_init), .q(init_s));
  cfg_sync_in #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
    .clk(clk), .rst_n(rst_n), .d(cfg_done), .q(done_s));

  assign arm        = (state_q == ST_IDLE) && start;
  assign shifting   = (state_q == ST_SHIFT);
  assign wait_run   = (state_q == ST_PROG) || (state_q == ST_WAIT_HI) ||
                      (state_q == ST_WAIT_DONE);
  assign wait_clear = (state_d != state_q);

  cfg_ms_watch #(.CLKS_PER_MS(CLKS_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_watch (
    .clk(clk), .rst_n(rst_n), .clear(wait_clear), .run(wait_run),
    .expired(expired));

  cfg_bit_feed #(.BYTE_W(BYTE_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .arm(arm), .bit_mode(bit_mode), .en(shifting),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .take(take), .bit_valid(bit_valid), .bit_val(bit_val), .bit_last(bit_last));

  cfg_bit_phaser #(.PHASE_CLKS(PHASE_CLKS)) u_phaser (
    .clk(clk), .rst_n(rst_n), .en(shifting), .bit_valid(bit_valid),
    .bit_val(bit_val), .bit_last(bit_last), .take(take), .cfg_clk(cfg_clk),
    .cfg_data(cfg_data), .finished(finished));

  always_comb begin
    state_d = state_q;
    fin     = 1'b0;
    fin_ok  = 1'b0;
    fin_err = ERR_NONE;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_PROG;
      ST_PROG: begin
        if (!init_s)      state_d = ST_WAIT_HI;
        else if (expired) begin fin = 1'b1; fin_err = ERR_INIT_LOW; end
      end
      ST_WAIT_HI: begin
        if (init_s)       state_d = ST_SHIFT;
        else if (expired) begin fin = 1'b1; fin_err = ERR_INIT_HIGH; end
      end
      ST_SHIFT: if (finished) state_d = ST_WAIT_DONE;
      ST_WAIT_DONE: begin
        if (done_s)       begin fin = 1'b1; fin_ok = 1'b1; end
        else if (expired) begin fin = 1'b1; fin_err = ERR_DONE; end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fin) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ok_q    <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      if (arm) begin
        ok_q  <= 1'b0;
        err_q <= ERR_NONE;
      end else if (fin) begin
        ok_q  <= fin_ok;
        err_q <= fin_err;
      end
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done_ok    = ok_q;
  assign error_code = err_q;
  assign cfg_prog   = PROG_ACTIVE_HIGH ? (state_q == ST_PROG) : (state_q != ST_PROG);
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk #(
  parameter bit PROG_ACTIVE_HIGH = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       s_valid,
  input logic       s_ready,
  input logic       cfg_prog,
  input logic       cfg_clk,
  input logic       cfg_data,
  input logic       done_ok,
  input logic [1:0] error_code
);
  // R1
  idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cfg_clk && cfg_data && (cfg_prog == !PROG_ACTIVE_HIGH)));

  // R3
  prog_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_prog == PROG_ACTIVE_HIGH) |-> busy);

  // R5
  rise_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $stable(cfg_data));

  // R5
  fall_data_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_clk) |-> cfg_data);

  // R11
  xfer_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> busy);

  // R10
  result_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> (error_code == 2'd0));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable({done_ok, error_code}));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(.PROG_ACTIVE_HIGH(PROG_ACTIVE_HIGH)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .s_valid(s_valid), .s_ready(s_ready),
  .cfg_prog(cfg_prog), .cfg_clk(cfg_clk), .cfg_data(cfg_data),
  .done_ok(done_ok), .error_code(error_code));

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;
  localparam int CPM = 16;
  localparam int TMS = 4;
  localparam int PHC = 2;
  localparam int TO_CYC = CPM * TMS;
  localparam logic [15:0] PFX = 16'hFF20;

  typedef struct packed {
    logic        bm;
    logic [2:0]  nb;
    logic [31:0] pay;
    logic [7:0]  lo_d;
    logic [7:0]  hi_d;
    logic [7:0]  dn_d;
    logic [1:0]  err;
  } vec_t;

  // 255 in a delay field = the target never answers
  localparam vec_t TBL [7] = '{
    '{1'b0, 3'd2, 32'hA53C_0000, 8'd3,   8'd3,   8'd5,   2'd0},
    '{1'b1, 3'd4, 32'h0100_0101, 8'd4,   8'd2,   8'd1,   2'd0},
    '{1'b0, 3'd1, 32'h8000_0000, 8'd55,  8'd55,  8'd50,  2'd0},
    '{1'b0, 3'd3, 32'hFF00_7E00, 8'd2,   8'd2,   8'd2,   2'd0},
    '{1'b0, 3'd1, 32'h5A00_0000, 8'd255, 8'd3,   8'd3,   2'd1},
    '{1'b0, 3'd1, 32'h5A00_0000, 8'd3,   8'd255, 8'd3,   2'd2},
    '{1'b1, 3'd2, 32'h0001_0000, 8'd3,   8'd3,   8'd255, 2'd3}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       bit_mode = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_last = 1'b0;
  logic       cfg_init = 1'b1;
  logic       cfg_done = 1'b0;
  logic       s_ready, cfg_prog, cfg_clk, cfg_data, busy, done_ok;
  logic [1:0] error_code;

  logic       hi_start = 1'b0;
  logic       hi_ready, hi_prog, hi_clk, hi_data, hi_busy, hi_ok;
  logic [1:0] hi_err;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cfg_serial_loader #(.CLKS_PER_MS(CPM), .TIMEOUT_MS(TMS), .PHASE_CLKS(PHC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_mode(bit_mode),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .cfg_init(cfg_init), .cfg_done(cfg_done), .cfg_prog(cfg_prog),
    .cfg_clk(cfg_clk), .cfg_data(cfg_data), .busy(busy), .done_ok(done_ok),
    .error_code(error_code));

  cfg_serial_loader #(.CLKS_PER_MS(CPM), .TIMEOUT_MS(TMS), .PHASE_CLKS(PHC),
                      .PROG_ACTIVE_HIGH(1'b1)) dut_hi_i (
    .clk(clk), .rst_n(rst_n), .start(hi_start), .bit_mode(1'b0),
    .s_valid(1'b0), .s_ready(hi_ready), .s_data(8'h00), .s_last(1'b0),
    .cfg_init(1'b1), .cfg_done(1'b0), .cfg_prog(hi_prog),
    .cfg_clk(hi_clk), .cfg_data(hi_data), .busy(hi_busy), .done_ok(hi_ok),
    .error_code(hi_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input vec_t v, input int i);
    logic [7:0] b;
    if (v.bm) begin
      if (i < 16) return PFX[15-i];
      b = v.pay[31-8*(i-16) -: 8];
      return b[0];
    end
    b = v.pay[31-8*(i/8) -: 8];
    return b[7-(i%8)];
  endfunction

  // environment: stream source, bit monitor, target model
  vec_t cv;
  bit   env_on = 1'b0;
  bit   took, prev_cclk;
  int   beat_i, cap_n, exp_n, cyc, lo_cnt, hi_cnt, dn_cnt;
  logic cap_bits [64];

  always @(negedge clk) begin
    if (env_on) begin
      cyc++;
      if (took) beat_i++;
      if (!s_valid || took) begin
        s_valid = (beat_i < int'(cv.nb)) && (cyc % 3 != 1);
        if (beat_i < int'(cv.nb)) begin
          s_data = cv.pay[31-8*beat_i -: 8];
          s_last = (beat_i == int'(cv.nb) - 1);
        end
      end
      took = s_valid && s_ready;
      if (cfg_clk && !prev_cclk) begin
        if (cap_n < 64) cap_bits[cap_n] = cfg_data;
        cap_n++;
      end
      prev_cclk = cfg_clk;
      if (!cfg_prog) begin
        cfg_done = 1'b0;
        hi_cnt = 0;
        if (cfg_init && cv.lo_d != 8'd255) begin
          if (lo_cnt >= int'(cv.lo_d)) cfg_init = 1'b0;
          else lo_cnt++;
        end
      end else if (!cfg_init && cv.hi_d != 8'd255) begin
        if (hi_cnt >= int'(cv.hi_d)) cfg_init = 1'b1;
        else hi_cnt++;
      end
      if (exp_n != 0 && cap_n == exp_n && cv.dn_d != 8'd255 && !cfg_done) begin
        if (dn_cnt >= int'(cv.dn_d)) cfg_done = 1'b1;
        else dn_cnt++;
      end
    end
  end

  task automatic run_vec(input vec_t v, input bit poke, input string tag);
    int n, rel, nbits, mism;
    bit prev_prog;
    cv = v;
    exp_n = (v.err == 2'd1 || v.err == 2'd2) ? 0 :
            (v.bm ? 16 + int'(v.nb) : 8 * int'(v.nb));
    cfg_init = 1'b1; cfg_done = 1'b0;
    lo_cnt = 0; hi_cnt = 0; dn_cnt = 0; beat_i = 0; cap_n = 0; cyc = 0;
    took = 1'b0; prev_cclk = 1'b1; s_valid = 1'b0;
    bit_mode = v.bm;
    env_on = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0; rel = -1; prev_prog = cfg_prog;
    while (busy && n < 4000) begin
      @(negedge clk);
      n++;
      if (!prev_prog && cfg_prog && rel < 0) rel = n;
      prev_prog = cfg_prog;
      if (poke && cap_n == 3) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n++;
        poke = 1'b0;
      end
    end
    env_on = 1'b0; s_valid = 1'b0;
    // R3 R4 R8: error code and success flag
    chk(error_code == v.err, {tag, " R8/R3/R4 error_code"}, error_code, v.err);
    chk(done_ok == (v.err == 2'd0), {tag, " R8 done_ok"}, done_ok, v.err == 2'd0);
    // R6 R7: bit count and order
    chk(cap_n == exp_n, {tag, " R6/R7 bit count"}, cap_n, exp_n);
    nbits = (cap_n < exp_n) ? cap_n : exp_n;
    mism = 0;
    for (int i = 0; i < nbits; i++) if (cap_bits[i] !== exp_bit(v, i)) mism++;
    chk(mism == 0, {tag, " R6/R7 bit values mismatches"}, mism, 0);
    // R1: idle levels after the sequence
    chk(cfg_prog && cfg_clk && cfg_data, {tag, " R1 idle levels"},
        {cfg_prog, cfg_clk, cfg_data}, 3'b111);
    // R9: timeout timing
    if (v.err == 2'd1) chk(n == TO_CYC, {tag, " R9 init-low timeout cycles"}, n, TO_CYC);
    if (v.err == 2'd2) chk(n - rel == TO_CYC, {tag, " R9 init-high timeout cycles"}, n - rel, TO_CYC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    s_valid = 1'b1;
    @(negedge clk);
    // R1 R11 R10: reset state
    chk(!busy, "R1 reset busy", busy, 0);
    chk(cfg_prog && cfg_clk && cfg_data, "R1 reset levels", {cfg_prog, cfg_clk, cfg_data}, 3'b111);
    chk(!s_ready, "R11 s_ready idle", s_ready, 0);
    chk(!done_ok && error_code == 2'd0, "R10 reset results", {done_ok, error_code}, 0);
    s_valid = 1'b0;

    // R2: active-high program polarity
    chk(!hi_prog, "R2 idle level active-high", hi_prog, 0);
    hi_start = 1'b1;
    @(negedge clk); hi_start = 1'b0;
    chk(hi_prog, "R2 asserted level active-high", hi_prog, 1);
    for (int k = 0; k < 200 && hi_busy; k++) @(negedge clk);
    chk(hi_err == 2'd1 && !hi_prog, "R3 active-high instance timeout", hi_err, 1);

    // vector table
    for (int t = 0; t < 7; t++) run_vec(TBL[t], 1'b0, $sformatf("vec%0d", t));

    // R10: start while shifting is ignored; results held while idle
    run_vec('{1'b0, 3'd1, 32'hC300_0000, 8'd2, 8'd2, 8'd2, 2'd0}, 1'b1, "restart");
    repeat (5) @(negedge clk);
    chk(!busy, "R10 no restart after poke", busy, 0);
    chk(done_ok && error_code == 2'd0, "R10 result held", {done_ok, error_code}, 3'b100);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule